// File: doc/BRIEF.md
# GPIO Interrupt Sense Controller

This block watches a bank of already-synchronized GPIO input pins and turns selected pin activity into interrupt requests. Each pin carries its own 4-bit sense code. The low three bits pick the condition: rising edge, falling edge, high level, low level or either edge. The top bit picks a faster detection path that skips one register stage. A per-pin acceptance bit decides whether a detected condition is allowed to latch.

Latched conditions collect in a vector of raw pending flags. Software clears these flags by writing ones. A separate mask vector has one write port that only sets bits and another that only clears bits, so software can change one pin without a read-modify-write. The masked status is the raw vector ANDed with the mask. It is reduced onto two interrupt lines, one for the lower half of the pins and one for the upper half. Software reaches all of this through a simple 32-bit register bus. Writes take effect on the clock edge and reads are combinational.

Top module: `gpio_irq_sense`

## Requirements
- R1: Code bits [2:0] select the condition: 0 rising edge, 1 falling edge, 2 high level, 3 low level, 4 either edge. Codes 5, 6 and 7 never set a pending flag.
- R2: With code bit 3 clear, detection compares the pin one and two cycles back, so a pending flag sets two edges after the pin changes. With bit 3 set, detection compares the pin now against one cycle back, so the flag sets on the first edge.
- R3: Pin n's code sits in the sense register at offset 0x40 + 4*(n>>3), bits [4*(n&7)+3 : 4*(n&7)]. The four sense registers at 0x40, 0x44, 0x48 and 0x4C read back what was written.
- R4: Offset 0x14 is a read/write acceptance vector. A pin whose acceptance bit is 0 never sets its pending flag.
- R5: Writing to 0x18 sets each mask bit whose data bit is 1 and leaves the others unchanged. A read of 0x18 returns 0.
- R6: Writing to 0x1C clears each mask bit whose data bit is 1 and leaves the others unchanged. A read of 0x1C returns the mask vector.
- R7: Writing to 0x28 clears each pending flag whose data bit is 1. Flags under zero bits are unchanged.
- R8: Offset 0x20 reads the raw pending vector. Offset 0x24 reads the raw vector ANDed with the mask.
- R9: In a level mode the flag sets again on every edge while the level holds. When a set and a clear reach the same flag on the same edge, the flag ends up set.
- R10: irq_lo is the OR of masked status bits 15..0. irq_hi is the OR of bits 31..16.
- R11: After reset, the sense codes, acceptance bits, mask bits and pending flags are all 0, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | 32 | Synchronized GPIO pin levels |
| irq_lo | output | 1 | Interrupt for pins 0..15 |
| irq_hi | output | 1 | Interrupt for pins 16..31 |

## Verification
The assertions assume the following about the inputs:
- reg_wdata is fully known whenever reg_wen is high.
- Each cycle carries at most one write, to one offset.
- pin_in changes only between clock edges, because the pins arrive already synchronized.

The stimulus keeps within these limits. It drives pins and bus fields only on the falling edge and returns reg_wen low after each write. It sweeps all sixteen sense codes, with edges and steady levels present on different pins at the same time, and then runs a long pseudo-random pin sequence under mixed per-pin codes with periodic clears.

// File: rtl/gis_pkg.sv
`timescale 1ns/1ps
package gis_pkg;
   localparam int CODE_W    = 4;
   localparam int ASYNC_BIT = 3;

   localparam int OFS_ACCEPT   = 'h14;
   localparam int OFS_MASK_ON  = 'h18;
   localparam int OFS_MASK_OFF = 'h1C;
   localparam int OFS_RAW      = 'h20;
   localparam int OFS_STATUS   = 'h24;
   localparam int OFS_CLEAR    = 'h28;
   localparam int OFS_SENSE0   = 'h40;

   typedef enum logic [2:0] {
      SENSE_RISE = 3'd0,
      SENSE_FALL = 3'd1,
      SENSE_HIGH = 3'd2,
      SENSE_LOW  = 3'd3,
      SENSE_BOTH = 3'd4
   } sense_kind_e;
endpackage

// File: rtl/gis_sense_detect.sv
`timescale 1ns/1ps
module gis_sense_detect #(
   parameter int NUM_PINS = 32,
   parameter bit ASYNC_EN = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_PINS-1:0]                  pin_in,
   input  logic [NUM_PINS*gis_pkg::CODE_W-1:0]  sense_codes,
   output logic [NUM_PINS-1:0]                  hit
);
   import gis_pkg::*;

   logic [NUM_PINS-1:0] early_q;
   logic [NUM_PINS-1:0] late_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         early_q <= '0;
         late_q  <= '0;
      end else begin
         early_q <= pin_in;
         late_q  <= early_q;
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [CODE_W-1:0] code;
      logic              cur;
      logic              prv;
      logic              h;

      assign code = sense_codes[p*CODE_W +: CODE_W];

      if (ASYNC_EN) begin : g_async
         assign cur = code[ASYNC_BIT] ? pin_in[p]  : early_q[p];
         assign prv = code[ASYNC_BIT] ? early_q[p] : late_q[p];
      end else begin : g_sync
         assign cur = early_q[p];
         assign prv = late_q[p];
      end

      always_comb begin
         case (sense_kind_e'(code[2:0]))
            SENSE_RISE: h = cur & ~prv;
            SENSE_FALL: h = ~cur & prv;
            SENSE_HIGH: h = cur;
            SENSE_LOW:  h = ~cur;
            SENSE_BOTH: h = cur ^ prv;
            default:    h = 1'b0;
         endcase
      end

      assign hit[p] = h;
   end
endmodule

// File: rtl/gis_pend_mask.sv
`timescale 1ns/1ps
module gis_pend_mask #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] set_vec,
   input  logic [NUM_PINS-1:0] clr_vec,
   input  logic [NUM_PINS-1:0] on_vec,
   input  logic [NUM_PINS-1:0] off_vec,
   output logic [NUM_PINS-1:0] raw_q,
   output logic [NUM_PINS-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         raw_q  <= (raw_q & ~clr_vec) | set_vec;
         mask_q <= (mask_q | on_vec) & ~off_vec;
      end
   end
endmodule

// File: rtl/gpio_irq_sense.sv
`timescale 1ns/1ps
module gpio_irq_sense #(
   parameter int NUM_PINS = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter bit ASYNC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic              irq_lo,
   output logic              irq_hi
);
   import gis_pkg::*;

   localparam int PINS_PER_REG   = DATA_W / CODE_W;
   localparam int NUM_SENSE_REGS = NUM_PINS / PINS_PER_REG;
   localparam int LO_PINS        = NUM_PINS / 2;

   if (NUM_PINS % PINS_PER_REG != 0 || NUM_PINS > DATA_W || NUM_PINS < 2) begin : g_bad_pins
      $error("gpio_irq_sense: NUM_PINS must be a multiple of %0d, at least 2 and at most DATA_W", PINS_PER_REG);
   end
   if (OFS_SENSE0 + 4 * NUM_SENSE_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_irq_sense: ADDR_W too small for the sense registers");
   end

   logic [NUM_PINS-1:0]        accept_q;
   logic [NUM_PINS-1:0]        hit_vec;
   logic [NUM_PINS-1:0]        set_vec;
   logic [NUM_PINS-1:0]        clr_vec;
   logic [NUM_PINS-1:0]        on_vec;
   logic [NUM_PINS-1:0]        off_vec;
   logic [NUM_PINS-1:0]        raw_pend;
   logic [NUM_PINS-1:0]        mask_en;
   logic [NUM_PINS-1:0]        status;
   logic [NUM_PINS*CODE_W-1:0] sense_flat;

   function automatic logic hit_ofs(input logic [ADDR_W-1:0] a, input int ofs);
      return reg_wen && (a == ADDR_W'(ofs));
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         accept_q <= '0;
      else if (hit_ofs(reg_addr, OFS_ACCEPT)) accept_q <= reg_wdata[NUM_PINS-1:0];
   end

   for (genvar k = 0; k < NUM_SENSE_REGS; k++) begin : g_sense
      logic [DATA_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     code_q <= '0;
         else if (hit_ofs(reg_addr, OFS_SENSE0 + 4 * k)) code_q <= reg_wdata;
      end
      assign sense_flat[k*DATA_W +: DATA_W] = code_q;
   end

   assign on_vec  = hit_ofs(reg_addr, OFS_MASK_ON)  ? reg_wdata[NUM_PINS-1:0] : '0;
   assign off_vec = hit_ofs(reg_addr, OFS_MASK_OFF) ? reg_wdata[NUM_PINS-1:0] : '0;
   assign clr_vec = hit_ofs(reg_addr, OFS_CLEAR)    ? reg_wdata[NUM_PINS-1:0] : '0;

   gis_sense_detect #(.NUM_PINS(NUM_PINS), .ASYNC_EN(ASYNC_EN)) u_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_in     (pin_in),
      .sense_codes(sense_flat),
      .hit        (hit_vec)
   );

   assign set_vec = hit_vec & accept_q;

   gis_pend_mask #(.NUM_PINS(NUM_PINS)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_vec(clr_vec),
      .on_vec (on_vec),
      .off_vec(off_vec),
      .raw_q  (raw_pend),
      .mask_q (mask_en)
   );

   assign status = raw_pend & mask_en;
   assign irq_lo = |status[LO_PINS-1:0];
   assign irq_hi = |status[NUM_PINS-1:LO_PINS];

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_ACCEPT))   reg_rdata = DATA_W'(accept_q);
      if (reg_addr == ADDR_W'(OFS_MASK_OFF)) reg_rdata = DATA_W'(mask_en);
      if (reg_addr == ADDR_W'(OFS_RAW))      reg_rdata = DATA_W'(raw_pend);
      if (reg_addr == ADDR_W'(OFS_STATUS))   reg_rdata = DATA_W'(status);
      for (int k = 0; k < NUM_SENSE_REGS; k++) begin
         if (reg_addr == ADDR_W'(OFS_SENSE0 + 4 * k))
            reg_rdata = sense_flat[k*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/gis_checker.sv
`timescale 1ns/1ps
module gis_checker #(
   parameter int NUM_PINS = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wen,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [DATA_W-1:0]   reg_wdata,
   input logic                irq_lo,
   input logic                irq_hi,
   input logic [NUM_PINS-1:0] raw_pend,
   input logic [NUM_PINS-1:0] mask_en,
   input logic [NUM_PINS-1:0] accept_vec,
   input logic [NUM_PINS-1:0] hit_vec
);
   localparam int LO_PINS = NUM_PINS / 2;

   logic                wr_on, wr_off, wr_clr;
   logic [NUM_PINS-1:0] wd;

   assign wr_on  = reg_wen && reg_addr == ADDR_W'(gis_pkg::OFS_MASK_ON);
   assign wr_off = reg_wen && reg_addr == ADDR_W'(gis_pkg::OFS_MASK_OFF);
   assign wr_clr = reg_wen && reg_addr == ADDR_W'(gis_pkg::OFS_CLEAR);
   assign wd     = reg_wdata[NUM_PINS-1:0];

   // R4: a flag can only newly set on a pin that was accepted
   a_r4_accept_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_pend & ~$past(raw_pend)) & ~$past(accept_vec)) == '0);

   // R5: the set-port write leaves every written-one bit enabled
   a_r5_mask_on: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_on) |-> (mask_en & $past(wd)) == $past(wd));

   // R6: the clear-port write leaves every written-one bit disabled
   a_r6_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_off) |-> (mask_en & $past(wd)) == '0);

   // R7: a cleared flag drops unless a new event hit it on the same edge
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_clr) |-> (raw_pend & $past(wd) & ~$past(hit_vec & accept_vec)) == '0);

   // R9: an accepted event always leaves its flag set
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hit_vec & accept_vec) & ~raw_pend) == '0);

   // R10: interrupt lines need an enabled pending pin in their half
   a_r10_irq_lo: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lo |-> |(raw_pend[LO_PINS-1:0] & mask_en[LO_PINS-1:0]));
   a_r10_irq_hi: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi |-> |(raw_pend[NUM_PINS-1:LO_PINS] & mask_en[NUM_PINS-1:LO_PINS]));
endmodule

bind gpio_irq_sense gis_checker #(
   .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_gis_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wen   (reg_wen),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .irq_lo    (irq_lo),
   .irq_hi    (irq_hi),
   .raw_pend  (raw_pend),
   .mask_en   (mask_en),
   .accept_vec(accept_q),
   .hit_vec   (hit_vec)
);

// File: tb/test_gpio_irq_sense.sv
`timescale 1ns/1ps
module test_gpio_irq_sense;
   localparam int NP = 32;
   localparam logic [31:0] OLD_PAT = 32'h00FF_00FF;
   localparam logic [31:0] NEW_PAT = 32'h0F0F_0F0F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wen = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] pin_in = '0;
   logic        irq_lo, irq_hi;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   gpio_irq_sense i_gpio_irq_sense (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   // reference model built from the requirements
   logic [31:0] m_s1 = '0, m_s2 = '0, m_raw = '0, m_mask = '0, m_acc = '0;
   logic [3:0]  m_sense [NP];

   function automatic logic cond_hit(input logic [3:0] c, input logic cur, input logic prv);
      case (c[2:0])
         3'd0:    return cur & ~prv;
         3'd1:    return ~cur & prv;
         3'd2:    return cur;
         3'd3:    return ~cur;
         3'd4:    return cur ^ prv;
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      logic [31:0] set_v;
      logic [31:0] clr_v;
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_raw <= '0; m_mask <= '0; m_acc <= '0;
         for (int p = 0; p < NP; p++) m_sense[p] <= '0;
      end else begin
         for (int p = 0; p < NP; p++) begin
            logic cur, prv;
            cur = m_sense[p][3] ? pin_in[p] : m_s1[p];
            prv = m_sense[p][3] ? m_s1[p]   : m_s2[p];
            set_v[p] = cond_hit(m_sense[p], cur, prv) & m_acc[p];
         end
         clr_v = (reg_wen && reg_addr == 8'h28) ? reg_wdata : '0;
         m_raw <= (m_raw & ~clr_v) | set_v;
         if (reg_wen) begin
            if (reg_addr == 8'h14) m_acc  <= reg_wdata;
            if (reg_addr == 8'h18) m_mask <= m_mask | reg_wdata;
            if (reg_addr == 8'h1C) m_mask <= m_mask & ~reg_wdata;
            if (reg_addr >= 8'h40 && reg_addr <= 8'h4C && reg_addr[1:0] == 2'b00) begin
               for (int j = 0; j < 8; j++)
                  m_sense[((reg_addr - 8'h40) >> 2) * 8 + j] <= reg_wdata[4*j +: 4];
            end
         end
         m_s1 <= pin_in;
         m_s2 <= m_s1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
      reg_addr = '0;
   endtask

   task automatic check_state(input string tag);
      logic [31:0] v, st;
      st = m_raw & m_mask;
      rd(8'h20, v); chk(tag, v, m_raw);
      rd(8'h24, v); chk("R8 masked status", v, st);
      chk("R10 irq_lo", {31'b0, irq_lo}, {31'b0, |st[15:0]});
      chk("R10 irq_hi", {31'b0, irq_hi}, {31'b0, |st[31:16]});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      logic [31:0] acc;
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      rd(8'h14, v); chk("R11 accept", v, 32'h0);
      rd(8'h1C, v); chk("R11 mask", v, 32'h0);
      for (int k = 0; k < 4; k++) begin
         rd(8'(8'h40 + 4 * k), v); chk("R11 sense", v, 32'h0);
      end
      check_state("R11 pending");

      // sweep every sense code over all pins
      for (int c = 0; c < 16; c++) begin
         wr(8'h14, 32'h0);
         for (int k = 0; k < 4; k++) wr(8'(8'h40 + 4 * k), {8{4'(c)}});
         rd(8'h40, v); chk("R3 readback", v, {8{4'(c)}});
         pin_in = OLD_PAT;
         repeat (3) @(negedge clk);
         wr(8'h28, 32'hFFFF_FFFF);
         check_state("R4 gated");
         rd(8'h14, v); chk("R4 accept zero", v, 32'h0);
         acc = ~(32'h0001_0101 << c);
         wr(8'h14, acc);
         rd(8'h14, v); chk("R4 accept readback", v, acc);
         pin_in = NEW_PAT;
         repeat (4) begin
            @(negedge clk);
            check_state(c >= 8 ? "R2 async detect" : "R1 sync detect");
         end
         wr(8'h18, 32'h00FF_F00F);
         rd(8'h1C, v); chk("R5 mask set", v, m_mask);
         rd(8'h18, v); chk("R5 set port reads zero", v, 32'h0);
         check_state("R5 status");
         wr(8'h1C, 32'h000F_0003);
         rd(8'h1C, v); chk("R6 mask clear", v, m_mask);
         check_state("R6 status");
         wr(8'h28, 32'hFFFF_FFFF);
         check_state("R9 set wins");
         @(negedge clk);
         check_state("R7 cleared");
         pin_in = OLD_PAT;
         repeat (2) begin
            @(negedge clk);
            check_state(c >= 8 ? "R2 async return" : "R1 sync return");
         end
         wr(8'h1C, 32'hFFFF_FFFF);
         rd(8'h1C, v); chk("R6 mask all off", v, 32'h0);
      end

      // mixed per-pin codes with random pin activity
      for (int k = 0; k < 4; k++) begin
         logic [31:0] w;
         for (int j = 0; j < 8; j++) w[4*j +: 4] = 4'((k * 8 + j) * 5 + 3);
         wr(8'(8'h40 + 4 * k), w);
         rd(8'(8'h40 + 4 * k), v); chk("R3 layout", v, w);
      end
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h1C, 32'h5A5A_A5A5);
      lfsr = 32'h1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         reg_wen = 1'b0;
         check_state("R3 mixed codes");
         pin_in = lfsr;
         lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
         if (i % 5 == 0) begin
            reg_wen = 1'b1; reg_addr = 8'h28; reg_wdata = lfsr;
         end
      end
      @(negedge clk);
      reg_wen = 1'b0; reg_addr = '0;
      check_state("R7 final");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule